// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block is the control engine that a processor core runs when it takes an interrupt or a software trap. It also runs the matching return. A trap request carries a vector number. The sequencer fetches the two-word gate for that vector from the interrupt descriptor table through a simple memory port. It compares the caller's privilege with the privilege recorded in the gate, and takes the kernel stack pointer and stack segment from the task-state record. It then writes the interrupted context onto that kernel stack, one word per cycle, and finally hands the core a new code selector, instruction pointer, flags word, stack and privilege level.

The return request runs the sequence backwards. It reads five words upward from the supplied stack pointer and hands back the restored context.

The memory port is single-issue. A read issued in one cycle returns its data on `mem_rdata` in the next cycle. A write completes in the cycle it is issued. The core keeps its live context outside the block. It presents that context on the `cur_*` inputs and takes the results from the `new_*` outputs when `done` pulses.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `mem_rd` and `mem_we` are low and every `new_*` output is zero.
- R2: An entry reads the gate at `idt_base + 8*vector` (handler instruction pointer) and then at `idt_base + 8*vector + 4`. In the second word, bits [15:0] are the new code selector and bits [17:16] are the gate privilege. Higher bits are ignored.
- R3: If `cur_cpl` is numerically greater than the gate privilege, `fault` pulses for one cycle. In that case the block makes no memory write, gives no `done`, and leaves every `new_*` output unchanged.
- R4: After the gate passes, the block reads the kernel stack pointer at `tss_base + 4` and the kernel stack segment at `tss_base + 8`, where only bits [15:0] are used.
- R5: An accepted entry makes exactly five writes, each 4 bytes below the previous one, starting at kernel stack pointer minus 4. The data order is: stack segment (zero-extended), stack pointer, flags, code selector (zero-extended), instruction pointer.
- R6: When an entry completes, `done` pulses and the outputs show the following. `new_eip` is the handler, `new_cs` is the gate selector, and `new_eflags` is the captured flags with bit 9 cleared. `new_ss` is the kernel segment, `new_esp` is the kernel stack pointer minus 20, and `new_cpl` is 0.
- R7: `busy` is high from the cycle after an accepted request until the cycle in which `done` or `fault` pulses. Requests that arrive while it is high are ignored.
- R8: A return reads five words at `cur_esp`, `+4`, `+8`, `+12` and `+16` as instruction pointer, code selector, flags, stack pointer and stack segment. It makes no writes and presents them on the outputs with `done`. `new_cpl` is taken from bits [1:0] of the popped selector.
- R9: A privilege equal to the gate privilege is accepted. A trap request takes priority over a return request that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Start an entry sequence |
| trap_vec | input | VEC_W | Vector number of the trap |
| ret_req | input | 1 | Start a return sequence |
| idt_base | input | ADDR_W | Byte base of the interrupt descriptor table |
| tss_base | input | ADDR_W | Byte base of the task-state record |
| cur_cs | input | SEL_W | Code selector of the interrupted context |
| cur_eip | input | DATA_W | Instruction pointer of the interrupted context |
| cur_eflags | input | DATA_W | Flags of the interrupted context |
| cur_ss | input | SEL_W | Stack segment of the interrupted context |
| cur_esp | input | ADDR_W | Stack pointer (user stack on entry, kernel stack on return) |
| cur_cpl | input | CPL_W | Current privilege level |
| mem_rd | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse, new context valid |
| fault | output | 1 | One-cycle protection-fault pulse |
| new_cs | output | SEL_W | Resulting code selector |
| new_eip | output | DATA_W | Resulting instruction pointer |
| new_eflags | output | DATA_W | Resulting flags |
| new_ss | output | SEL_W | Resulting stack segment |
| new_esp | output | ADDR_W | Resulting stack pointer |
| new_cpl | output | CPL_W | Resulting privilege level |

## Verification
Random entries draw the vector, the caller and gate privilege, the flags, the user context, the task-state location and the kernel stack pointer. Garbage is placed in the unused gate and segment bits. Each accepted entry is followed by a return from the stack it built, so a swapped push slot, a wrong step, or a stale flag shows up twice: once in the write log and once in the restored context. Directed cases cover equal privilege, the most and least privileged faults, the highest vector, a trap and a return requested together, and extra requests while busy. Together these separate the fault path from the accepted path, and a dropped request from a doubled one.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ERD,
      ST_ECAP,
      ST_PUSH,
      ST_RRD,
      ST_RCAP,
      ST_FIN
   } trap_st_t;

   localparam int FRAME_WORDS = 5;
   localparam int ENTRY_READS = 4;
endpackage

// File: rtl/trap_gate_dec.sv
module trap_gate_dec #(
   parameter int DATA_W = 32,
   parameter int SEL_W  = 16,
   parameter int CPL_W  = 2
) (
   input  logic [DATA_W-1:0] gate_hi,
   input  logic [CPL_W-1:0]  cpl_in,
   output logic [SEL_W-1:0]  sel,
   output logic [CPL_W-1:0]  dpl,
   output logic              allow
);
   localparam int USED_W = SEL_W + CPL_W;

   generate
      if (USED_W > DATA_W) begin : g_bad_w
         $error("gate fields wider than data word");
      end
      if (USED_W < DATA_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^gate_hi[DATA_W-1:USED_W];
      end
   endgenerate

   assign sel   = gate_hi[SEL_W-1:0];
   assign dpl   = gate_hi[SEL_W +: CPL_W];
   assign allow = (cpl_in <= dpl);
endmodule

// File: rtl/trap_addr_gen.sv
module trap_addr_gen
   import trap_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int VEC_W      = 5,
   parameter int WORD_BYTES = 4
) (
   input  trap_st_t          st,
   input  logic [2:0]        idx,
   input  logic [ADDR_W-1:0] idt_base,
   input  logic [ADDR_W-1:0] tss_base,
   input  logic [VEC_W-1:0]  vec,
   input  logic [ADDR_W-1:0] sp,
   output logic [ADDR_W-1:0] addr
);
   localparam int GATE_SH = $clog2(2 * WORD_BYTES);
   localparam logic [ADDR_W-1:0] WB = ADDR_W'(WORD_BYTES);

   generate
      if ((WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_wb
         $error("WORD_BYTES must be a power of two");
      end
      if (VEC_W + GATE_SH > ADDR_W) begin : g_bad_vec
         $error("vector offset exceeds address width");
      end
   endgenerate

   logic [ADDR_W-1:0] gate_off;
   assign gate_off = {{(ADDR_W-VEC_W){1'b0}}, vec} << GATE_SH;

   always_comb begin
      addr = '0;
      case (st)
         ST_ERD: begin
            case (idx)
               3'd0:    addr = idt_base + gate_off;
               3'd1:    addr = idt_base + gate_off + WB;
               3'd2:    addr = tss_base + WB;
               default: addr = tss_base + (WB << 1);
            endcase
         end
         ST_PUSH: addr = sp - WB;
         ST_RRD:  addr = sp;
         default: addr = '0;
      endcase
   end
endmodule

// File: rtl/trap_frame_sel.sv
module trap_frame_sel
   import trap_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int SEL_W  = 16
) (
   input  logic [SEL_W-1:0]  ss,
   input  logic [ADDR_W-1:0] esp,
   input  logic [DATA_W-1:0] eflags,
   input  logic [SEL_W-1:0]  cs,
   input  logic [DATA_W-1:0] eip,
   input  logic [2:0]        idx,
   output logic [DATA_W-1:0] word
);
   logic [DATA_W-1:0] slot [FRAME_WORDS];
   logic [DATA_W-1:0] ss_w;
   logic [DATA_W-1:0] cs_w;

   generate
      if (SEL_W > DATA_W || ADDR_W != DATA_W) begin : g_bad_w
         $error("frame widths do not fit the data word");
      end
      if (SEL_W < DATA_W) begin : g_pad
         assign ss_w = {{(DATA_W-SEL_W){1'b0}}, ss};
         assign cs_w = {{(DATA_W-SEL_W){1'b0}}, cs};
      end else begin : g_nopad
         assign ss_w = ss;
         assign cs_w = cs;
      end
   endgenerate

   // push order: segment, pointer, flags, selector, instruction pointer
   assign slot[0] = ss_w;
   assign slot[1] = esp;
   assign slot[2] = eflags;
   assign slot[3] = cs_w;
   assign slot[4] = eip;

   assign word = (int'(idx) < FRAME_WORDS) ? slot[idx] : '0;
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
   import trap_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int NVEC       = 32,
   parameter int SEL_W      = 16,
   parameter int CPL_W      = 2,
   parameter int IF_BIT     = 9,
   parameter int WORD_BYTES = 4,
   localparam int VEC_W     = $clog2(NVEC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_req,
   input  logic [VEC_W-1:0]  trap_vec,
   input  logic              ret_req,
   input  logic [ADDR_W-1:0] idt_base,
   input  logic [ADDR_W-1:0] tss_base,
   input  logic [SEL_W-1:0]  cur_cs,
   input  logic [DATA_W-1:0] cur_eip,
   input  logic [DATA_W-1:0] cur_eflags,
   input  logic [SEL_W-1:0]  cur_ss,
   input  logic [ADDR_W-1:0] cur_esp,
   input  logic [CPL_W-1:0]  cur_cpl,
   output logic              mem_rd,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [SEL_W-1:0]  new_cs,
   output logic [DATA_W-1:0] new_eip,
   output logic [DATA_W-1:0] new_eflags,
   output logic [SEL_W-1:0]  new_ss,
   output logic [ADDR_W-1:0] new_esp,
   output logic [CPL_W-1:0]  new_cpl
);
   localparam logic [ADDR_W-1:0] WB      = ADDR_W'(WORD_BYTES);
   localparam logic [DATA_W-1:0] IF_MASK = DATA_W'(1) << IF_BIT;
   localparam logic [2:0] LAST_RD  = 3'(ENTRY_READS - 1);
   localparam logic [2:0] LAST_WR  = 3'(FRAME_WORDS - 1);

   generate
      if (NVEC < 2) begin : g_bad_nvec
         $error("NVEC must be at least 2");
      end
      if (IF_BIT >= DATA_W) begin : g_bad_if
         $error("IF_BIT outside the flags word");
      end
   endgenerate

   trap_st_t          st;
   logic [2:0]        idx;
   logic [ADDR_W-1:0] sp;
   logic              is_ret;
   logic              done_q, fault_q;
   logic [VEC_W-1:0]  c_vec;
   logic [SEL_W-1:0]  c_cs, c_ss;
   logic [DATA_W-1:0] c_eip, c_eflags;
   logic [ADDR_W-1:0] c_esp;
   logic [CPL_W-1:0]  c_cpl;
   logic [DATA_W-1:0] rd [FRAME_WORDS];

   logic [DATA_W-1:0] gate_hi_in;
   logic [SEL_W-1:0]  g_sel;
   logic [CPL_W-1:0]  g_dpl;
   logic              g_allow;
   logic              unused_bits;

   assign unused_bits = ^{g_dpl, rd[1][DATA_W-1:SEL_W], rd[3][DATA_W-1:SEL_W],
                          rd[4][DATA_W-1:SEL_W]};

   assign gate_hi_in = (st == ST_ECAP) ? mem_rdata : rd[1];

   trap_gate_dec #(.DATA_W(DATA_W), .SEL_W(SEL_W), .CPL_W(CPL_W)) i_gate (
      .gate_hi (gate_hi_in),
      .cpl_in  (c_cpl),
      .sel     (g_sel),
      .dpl     (g_dpl),
      .allow   (g_allow)
   );

   trap_addr_gen #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .WORD_BYTES(WORD_BYTES)) i_agen (
      .st       (st),
      .idx      (idx),
      .idt_base (idt_base),
      .tss_base (tss_base),
      .vec      (c_vec),
      .sp       (sp),
      .addr     (mem_addr)
   );

   trap_frame_sel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) i_frame (
      .ss     (c_ss),
      .esp    (c_esp),
      .eflags (c_eflags),
      .cs     (c_cs),
      .eip    (c_eip),
      .idx    (idx),
      .word   (mem_wdata)
   );

   assign mem_rd = (st == ST_ERD) || (st == ST_RRD);
   assign mem_we = (st == ST_PUSH);
   assign busy   = (st != ST_IDLE);
   assign done   = done_q;
   assign fault  = fault_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         idx      <= '0;
         sp       <= '0;
         is_ret   <= 1'b0;
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
         c_vec    <= '0;
         c_cs     <= '0;
         c_ss     <= '0;
         c_eip    <= '0;
         c_eflags <= '0;
         c_esp    <= '0;
         c_cpl    <= '0;
         for (int i = 0; i < FRAME_WORDS; i++) rd[i] <= '0;
         new_cs     <= '0;
         new_eip    <= '0;
         new_eflags <= '0;
         new_ss     <= '0;
         new_esp    <= '0;
         new_cpl    <= '0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               idx <= '0;
               if (trap_req) begin
                  is_ret   <= 1'b0;
                  c_vec    <= trap_vec;
                  c_cs     <= cur_cs;
                  c_ss     <= cur_ss;
                  c_eip    <= cur_eip;
                  c_eflags <= cur_eflags;
                  c_esp    <= cur_esp;
                  c_cpl    <= cur_cpl;
                  st       <= ST_ERD;
               end else if (ret_req) begin
                  is_ret <= 1'b1;
                  sp     <= cur_esp;
                  st     <= ST_RRD;
               end
            end
            ST_ERD: st <= ST_ECAP;
            ST_ECAP: begin
               rd[idx] <= mem_rdata;
               if (idx == 3'd1 && !g_allow) begin
                  fault_q <= 1'b1;
                  st      <= ST_IDLE;
               end else if (idx == LAST_RD) begin
                  idx <= '0;
                  st  <= ST_PUSH;
               end else begin
                  if (idx == 3'd2) sp <= mem_rdata;
                  idx <= idx + 3'd1;
                  st  <= ST_ERD;
               end
            end
            ST_PUSH: begin
               sp <= sp - WB;
               if (idx == LAST_WR) st <= ST_FIN;
               else idx <= idx + 3'd1;
            end
            ST_RRD: st <= ST_RCAP;
            ST_RCAP: begin
               rd[idx] <= mem_rdata;
               sp      <= sp + WB;
               if (idx == LAST_WR) st <= ST_FIN;
               else begin
                  idx <= idx + 3'd1;
                  st  <= ST_RRD;
               end
            end
            ST_FIN: begin
               done_q <= 1'b1;
               st     <= ST_IDLE;
               if (is_ret) begin
                  new_eip    <= rd[0];
                  new_cs     <= rd[1][SEL_W-1:0];
                  new_eflags <= rd[2];
                  new_esp    <= rd[3];
                  new_ss     <= rd[4][SEL_W-1:0];
                  new_cpl    <= rd[1][CPL_W-1:0];
               end else begin
                  new_eip    <= rd[0];
                  new_cs     <= g_sel;
                  new_eflags <= c_eflags & ~IF_MASK;
                  new_ss     <= rd[3][SEL_W-1:0];
                  new_esp    <= sp;
                  new_cpl    <= '0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R5
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - WB));

   // R7
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || fault));

   // R3
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!done && !$past(mem_we)));

   // R6
   entry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !is_ret) |-> (!new_eflags[IF_BIT] && new_cpl == '0));

   // R8
   ret_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && is_ret) |-> !mem_we);

   // R1
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_we));
endmodule

// File: tb/test_trap_entry_seq.sv
`timescale 1ns/1ps
module test_trap_entry_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_req = 1'b0;
   logic [4:0]  trap_vec = '0;
   logic        ret_req = 1'b0;
   logic [31:0] idt_base = 32'h0;
   logic [31:0] tss_base = 32'h100;
   logic [15:0] cur_cs = '0, cur_ss = '0;
   logic [31:0] cur_eip = '0, cur_eflags = '0, cur_esp = '0;
   logic [1:0]  cur_cpl = '0;
   logic        mem_rd, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        busy, done, fault;
   logic [15:0] new_cs, new_ss;
   logic [31:0] new_eip, new_eflags, new_esp;
   logic [1:0]  new_cpl;

   always #10 clk = ~clk;

   trap_entry_seq i_trap_entry_seq (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_vec(trap_vec),
      .ret_req(ret_req), .idt_base(idt_base), .tss_base(tss_base),
      .cur_cs(cur_cs), .cur_eip(cur_eip), .cur_eflags(cur_eflags),
      .cur_ss(cur_ss), .cur_esp(cur_esp), .cur_cpl(cur_cpl),
      .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
      .done(done), .fault(fault), .new_cs(new_cs), .new_eip(new_eip),
      .new_eflags(new_eflags), .new_ss(new_ss), .new_esp(new_esp),
      .new_cpl(new_cpl)
   );

   // bench memory: 256 words, one-cycle read latency
   logic [31:0] mem [256];
   logic        tb_we = 1'b0;
   logic [31:0] tb_a = '0, tb_d = '0;
   int unsigned wr_cnt = 0;
   logic [31:0] log_a [1024];
   logic [31:0] log_d [1024];

   always @(posedge clk) begin
      if (tb_we) mem[tb_a[9:2]] <= tb_d;
      if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) begin
         mem[mem_addr[9:2]] <= mem_wdata;
         log_a[wr_cnt % 1024] <= mem_addr;
         log_d[wr_cnt % 1024] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
   end

   int unsigned checks = 0, fails = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_flags(input logic [31:0] f);
      return f & ~32'h0000_0200;
   endfunction

   task automatic bwrite(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      tb_we = 1'b1; tb_a = a; tb_d = d;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   // waits for done or fault; returns 0 on done, 1 on fault, 2 on timeout
   task automatic wait_end(output int res);
      res = 2;
      for (int c = 0; c < 200; c++) begin
         if (done) begin res = 0; break; end
         if (fault) begin res = 1; break; end
         @(negedge clk);
      end
      if (res == 2) chk(1'b0, "R7 timeout", 32'(busy), 32'h0);
   endtask

   // one full entry (plus return if accepted)
   task automatic run_trap(input logic [4:0] vec, input logic [1:0] cpl,
                           input logic [1:0] dpl, input bit dual, input bit poke);
      logic [31:0] handler, ghi, esp0, ss0w, eip, efl, uesp, tss;
      logic [15:0] sel, ucs, uss;
      logic [15:0] p_cs; logic [31:0] p_eip, p_esp;
      int unsigned base;
      int res;
      bit exp_fault;
      handler = $urandom; sel = 16'($urandom);
      ghi  = {14'($urandom), dpl, sel};
      tss  = 32'h100 + 32'(4 * ($urandom % 60));
      esp0 = 32'h300 + 32'(4 * ($urandom % 64));
      ss0w = $urandom;
      eip = $urandom; efl = $urandom; uesp = $urandom;
      ucs = 16'($urandom); uss = 16'($urandom);
      if (poke) efl[9] = 1'b1;
      bwrite(idt_base + {24'h0, vec, 3'b000}, handler);
      bwrite(idt_base + {24'h0, vec, 3'b000} + 32'd4, ghi);
      bwrite(tss + 32'd4, esp0);
      bwrite(tss + 32'd8, ss0w);
      tss_base = tss;
      cur_cs = ucs; cur_ss = uss; cur_eip = eip; cur_eflags = efl;
      cur_esp = uesp; cur_cpl = cpl;
      p_cs = new_cs; p_eip = new_eip; p_esp = new_esp;
      base = wr_cnt;
      exp_fault = (cpl > dpl);
      @(negedge clk);
      trap_req = 1'b1; trap_vec = vec; ret_req = dual;
      @(negedge clk);
      trap_req = 1'b0; ret_req = 1'b0;
      chk(busy == 1'b1, "R7 busy after request", 32'(busy), 32'h1);
      if (poke) begin
         @(negedge clk);
         trap_req = 1'b1; trap_vec = vec + 5'd1; ret_req = 1'b1; cur_eip = ~eip;
         @(negedge clk);
         trap_req = 1'b0; ret_req = 1'b0; cur_eip = eip;
      end
      wait_end(res);
      if (res == 2) return;
      if (exp_fault) begin
         chk(res == 1, "R3 fault expected", 32'(res), 32'h1);
         chk(busy == 1'b0, "R7 busy low at fault", 32'(busy), 32'h0);
         @(negedge clk);
         chk(wr_cnt == base, "R3 no writes on fault", wr_cnt - base, 32'h0);
         chk(new_eip == p_eip && new_cs == p_cs && new_esp == p_esp,
             "R3 outputs unchanged", new_eip, p_eip);
         chk(done == 1'b0 && fault == 1'b0, "R3 single pulse", {done, fault}, 32'h0);
         return;
      end
      chk(res == 0, "R9 R3 accepted entry", 32'(res), 32'h0);
      chk(busy == 1'b0, "R7 busy low at done", 32'(busy), 32'h0);
      chk(new_eip == handler, "R2 R6 handler ip", new_eip, handler);
      chk(new_cs == sel, "R2 R6 gate selector", 32'(new_cs), 32'(sel));
      chk(new_eflags == exp_flags(efl), "R6 flags bit9 cleared", new_eflags, exp_flags(efl));
      chk(new_ss == ss0w[15:0], "R4 R6 kernel segment", 32'(new_ss), 32'(ss0w[15:0]));
      chk(new_esp == esp0 - 32'd20, "R4 R6 kernel sp", new_esp, esp0 - 32'd20);
      chk(new_cpl == 2'd0, "R6 cpl zero", 32'(new_cpl), 32'h0);
      chk(wr_cnt - base == 5, "R5 five pushes", wr_cnt - base, 32'd5);
      if (wr_cnt - base == 5) begin
         logic [31:0] fr [5];
         fr[0] = {16'h0, uss}; fr[1] = uesp; fr[2] = efl; fr[3] = {16'h0, ucs}; fr[4] = eip;
         for (int k = 0; k < 5; k++) begin
            chk(log_a[(base + k) % 1024] == esp0 - 32'(4 * (k + 1)), "R5 push addr",
                log_a[(base + k) % 1024], esp0 - 32'(4 * (k + 1)));
            chk(log_d[(base + k) % 1024] == fr[k], "R5 push data",
                log_d[(base + k) % 1024], fr[k]);
         end
      end
      // return from the frame just built
      cur_esp = new_esp;
      base = wr_cnt;
      @(negedge clk);
      ret_req = 1'b1;
      @(negedge clk);
      ret_req = 1'b0;
      chk(busy == 1'b1, "R7 busy on return", 32'(busy), 32'h1);
      wait_end(res);
      if (res == 2) return;
      chk(res == 0, "R8 return done", 32'(res), 32'h0);
      chk(new_eip == eip, "R8 pop ip", new_eip, eip);
      chk(new_cs == ucs, "R8 pop cs", 32'(new_cs), 32'(ucs));
      chk(new_eflags == efl, "R8 pop flags", new_eflags, efl);
      chk(new_esp == uesp, "R8 pop sp", new_esp, uesp);
      chk(new_ss == uss, "R8 pop ss", 32'(new_ss), 32'(uss));
      chk(new_cpl == ucs[1:0], "R8 cpl from cs", 32'(new_cpl), 32'(ucs[1:0]));
      chk(wr_cnt == base, "R8 no writes", wr_cnt - base, 32'h0);
   endtask

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !fault, "R1 status low", {busy, done, fault}, 32'h0);
      chk(!mem_rd && !mem_we, "R1 strobes low", {mem_rd, mem_we}, 32'h0);
      chk(new_eip == 0 && new_esp == 0 && new_eflags == 0 && new_cs == 0 &&
          new_ss == 0 && new_cpl == 0, "R1 outputs zero", new_eip, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      run_trap(5'd3, 2'd3, 2'd3, 1'b0, 1'b1);   // R9 equal privilege, R6 IF set, R7 pokes
      run_trap(5'd31, 2'd0, 2'd0, 1'b0, 1'b0);  // R2 top vector
      run_trap(5'd7, 2'd3, 2'd0, 1'b0, 1'b0);   // R3 fault
      run_trap(5'd8, 2'd1, 2'd0, 1'b0, 1'b0);   // R3 fault by one level
      run_trap(5'd9, 2'd2, 2'd3, 1'b1, 1'b0);   // R9 trap wins over return
      run_trap(5'd0, 2'd3, 2'd2, 1'b0, 1'b1);   // R3 fault with pokes
      // random
      for (int n = 0; n < 40; n++)
         run_trap(5'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'b0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R7 watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule